// File: doc/BRIEF.md
# Per-Set Variable-Way Cache Tag Lookup

This block is the tag and lookup stage of a set-associative cache in which every set owns its own number of usable ways. The count of each set is fixed at elaboration through a parameter table; it cannot change while the cache is running. At reset each tag entry gets a second valid bit, here called the *unused* bit, loaded from that table. A block whose unused bit is set never produces a hit and is never picked for replacement.

A request presents an address with `req_valid`. In the same cycle the block returns `hit` and `hit_way`, along with the way that the next allocation into that set would take (`victim_way`). It also returns a per-way read enable for the tag and data sense amplifiers. That enable is decoded from the set-index field alone, so ways that a set does not use are never read. An allocation (`fill_valid`, `fill_addr`) writes the tag into the current victim way of the fill set and advances that set's round-robin pointer. It takes effect at the next rising clock edge.

The address splits into three fields. The low `OFF_W` bits are the line offset, the next `IDX_W` bits are the set index, and the remaining upper bits are the tag. `SET_WAYS` packs one `CNT_W`-bit way count per set, with set *s* at bits `[s*CNT_W +: CNT_W]`. Active ways are always the lowest-numbered ones.

Top module: `vw_cache_lookup`

## Requirements
- R1: Reset (`rst_n` low) clears every valid bit and every round-robin pointer. After reset, every lookup misses and every set reports victim way 0.
- R2: `rd_en` bit *w* is 1 exactly when `req_valid` is 1 and way *w* is active in the set selected by the request address. With the default table the values are: sets 0–1 give `4'b1111`, sets 2–3 give `4'b0011`, and sets 4–7 give `4'b0001`. With `req_valid` at 0, `rd_en` is all zero.
- R3: Way 0 is active in every set, so bit 0 of `rd_en` is 1 on every valid request.
- R4: After a fill of an address, a lookup of the same address reports `hit`=1. Its `hit_way` equals the `victim_way` that was shown for that set just before the fill.
- R5: `hit` is 0 whenever `req_valid` is 0, and whenever no valid, active way of the set holds the request tag.
- R6: The victim of a set cycles through its active ways in ascending order and wraps to way 0. A 4-way set gives 0,1,2,3,0; a 2-way set gives 0,1,0; a 1-way set always gives 0. The pointer advances only on a fill to that set.
- R7: A fill that reuses a way evicts the tag that way held, so a later lookup of that tag misses. Tags in the other ways of the set still hit.
- R8: A way that is unused for a set is never reported as `hit_way` on a hit, and never reported as `victim_way` on a valid request.
- R9: Fills to one set change neither the contents nor the victim pointer of any other set. This holds even when the same tag is used in both sets.
- R10: `hit_way` is 0 whenever `hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request present this cycle |
| req_addr | input | ADDR_W | Lookup address |
| fill_valid | input | 1 | Allocate `fill_addr` into its set's victim way |
| fill_addr | input | ADDR_W | Address to allocate |
| hit | output | 1 | Request tag found in a valid, active way |
| hit_way | output | WAY_W | Way that hit, 0 on a miss |
| victim_way | output | WAY_W | Next replacement way of the request set |
| rd_en | output | NUM_WAYS | Per-way tag/data sense-amplifier enable |

## Verification
The bench uses the default parameters: 12-bit addresses, 8 sets, 4 ways, and the table 4,4,2,2,1,1,1,1. This gives one set of each width class, so the three round-robin wrap lengths (4, 2 and 1) can all be exercised. It also shows that the read-enable mask is narrower in the smaller sets. Reusing one tag across sets of different widths brings set isolation and eviction within reach, and a 1-way set shows immediate replacement on every fill.

// File: rtl/vw_cache_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the variable-way cache lookup.
// Assumes way counts are small integers; way 0 is always treated as active.
package vw_cache_pkg;

    // Width of an index into n items, never below one bit.
    function automatic int idx_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // True when way w falls outside the usable ways of a set with cnt ways.
    function automatic bit way_is_unused(input int cnt, input int w);
        if (w == 0) return 1'b0;
        return (w >= cnt);
    endfunction

endpackage

// File: rtl/vw_way_map.sv
`timescale 1ns/1ps
// Module: per-set unused-way map (the second valid bit of every block).
// Loads the pattern from the SET_WAYS table at reset and holds it after.
// Assumes active ways of a set are the lowest-numbered ones.
module vw_way_map
    import vw_cache_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 4,
    parameter logic [NUM_SETS*CNT_W-1:0] SET_WAYS = '0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    output logic [NUM_SETS-1:0][NUM_WAYS-1:0]  unused_q
);

    logic [NUM_SETS-1:0][NUM_WAYS-1:0] unused_init;

    // Build the reset pattern from the way-count table.
    generate
        for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
            localparam int CNT = int'(SET_WAYS[s*CNT_W +: CNT_W]);
            for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
                localparam bit UNUSED = way_is_unused(CNT, w);
                assign unused_init[s][w] = UNUSED;
            end
        end
    endgenerate

    // Unused bits: loaded at reset, held for the rest of the run.
    always_ff @(posedge clk) begin
        if (!rst_n) unused_q <= unused_init;
        else        unused_q <= unused_q;
    end

endmodule

// File: rtl/vw_tag_array.sv
`timescale 1ns/1ps
// Module: tag and valid storage, one write port (fill) and one read row.
// Assumes the fill way is always an active way of the fill set.
module vw_tag_array #(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 7,
    parameter int IDX_W    = 3,
    parameter int WAY_W    = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_set,
    input  logic [WAY_W-1:0]                  wr_way,
    input  logic [TAG_W-1:0]                  wr_tag,
    input  logic [IDX_W-1:0]                  rd_set,
    output logic [NUM_WAYS-1:0]               rd_valid,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]    rd_tag
);

    logic [NUM_SETS-1:0][NUM_WAYS-1:0]            valid_q;
    logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0] tag_q;

    // Storage update: clear on reset, write one entry per fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
            tag_q[wr_set][wr_way]   <= wr_tag;
        end
    end

    // Read row of the requested set.
    always_comb begin
        rd_valid = valid_q[rd_set];
        rd_tag   = tag_q[rd_set];
    end

endmodule

// File: rtl/vw_victim_sel.sv
`timescale 1ns/1ps
// Module: per-set round-robin replacement pointer over active ways only.
// Assumes way 0 of every set is active, so wrapping to 0 is always legal.
module vw_victim_sel #(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    parameter int IDX_W    = 3,
    parameter int WAY_W    = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SETS-1:0][NUM_WAYS-1:0] unused,
    input  logic [IDX_W-1:0]                  req_set,
    input  logic                              adv_en,
    input  logic [IDX_W-1:0]                  adv_set,
    output logic [WAY_W-1:0]                  req_victim,
    output logic [WAY_W-1:0]                  adv_victim
);

    logic [NUM_SETS-1:0][WAY_W-1:0] ptr_q;
    logic [NUM_SETS-1:0][WAY_W-1:0] ptr_nxt;

    // Next active way above each set's pointer, or 0 when none is left.
    always_comb begin
        for (int s = 0; s < NUM_SETS; s++) begin
            ptr_nxt[s] = '0;
            for (int w = NUM_WAYS - 1; w >= 1; w--) begin
                if (w > int'(ptr_q[s]) && !unused[s][w]) ptr_nxt[s] = WAY_W'(w);
            end
        end
    end

    // Pointer update: advance only the set that was filled.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (adv_en) ptr_q[adv_set] <= ptr_nxt[adv_set];
    end

    // Victim read ports for the request set and the fill set.
    always_comb begin
        req_victim = ptr_q[req_set];
        adv_victim = ptr_q[adv_set];
    end

endmodule

// File: rtl/vw_cache_lookup.sv
`timescale 1ns/1ps
// Module: variable-way cache tag lookup (top).
// Combinational hit/victim/read-enable from the current request and state;
// fills land on the next rising edge. Way counts come from SET_WAYS.
module vw_cache_lookup
    import vw_cache_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    parameter int OFF_W    = 2,
    parameter int CNT_W    = 4,
    parameter logic [NUM_SETS*CNT_W-1:0] SET_WAYS = 32'h1111_2244,
    localparam int IDX_W   = idx_width(NUM_SETS),
    localparam int WAY_W   = idx_width(NUM_WAYS),
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 fill_valid,
    input  logic [ADDR_W-1:0]    fill_addr,
    output logic                 hit,
    output logic [WAY_W-1:0]     hit_way,
    output logic [WAY_W-1:0]     victim_way,
    output logic [NUM_WAYS-1:0]  rd_en
);

    logic [IDX_W-1:0]                  req_set, fill_set;
    logic [TAG_W-1:0]                  req_tag, fill_tag;
    logic [NUM_SETS-1:0][NUM_WAYS-1:0] unused;
    logic [NUM_WAYS-1:0]               row_valid;
    logic [NUM_WAYS-1:0][TAG_W-1:0]    row_tag;
    logic [NUM_WAYS-1:0]               way_match;
    logic [WAY_W-1:0]                  fill_way;

    // Address field split.
    always_comb begin
        req_set  = req_addr[OFF_W +: IDX_W];
        req_tag  = req_addr[ADDR_W-1 -: TAG_W];
        fill_set = fill_addr[OFF_W +: IDX_W];
        fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
    end

    vw_way_map #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS),
        .CNT_W    (CNT_W),
        .SET_WAYS (SET_WAYS)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .unused_q (unused)
    );

    vw_tag_array #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W),
        .IDX_W    (IDX_W),
        .WAY_W    (WAY_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_valid),
        .wr_set   (fill_set),
        .wr_way   (fill_way),
        .wr_tag   (fill_tag),
        .rd_set   (req_set),
        .rd_valid (row_valid),
        .rd_tag   (row_tag)
    );

    vw_victim_sel #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS),
        .IDX_W    (IDX_W),
        .WAY_W    (WAY_W)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .unused     (unused),
        .req_set    (req_set),
        .adv_en     (fill_valid),
        .adv_set    (fill_set),
        .req_victim (victim_way),
        .adv_victim (fill_way)
    );

    // Per-way compare, gated by request, valid bit and unused bit.
    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
            assign way_match[w] = req_valid && row_valid[w] && !unused[req_set][w]
                                  && (row_tag[w] == req_tag);
        end
    endgenerate

    // Sense-amplifier enables decoded from the set index only.
    always_comb begin
        rd_en = req_valid ? ~unused[req_set] : '0;
    end

    // Hit flag and lowest matching way.
    always_comb begin
        hit     = |way_match;
        hit_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// Module: property checker for vw_cache_lookup, attached by bind below.
// Observes ports only; assumes synchronous active-low reset.
module vw_cache_lookup_chk #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                hit,
    input logic [WAY_W-1:0]    hit_way,
    input logic [WAY_W-1:0]    victim_way,
    input logic [NUM_WAYS-1:0] rd_en
);

    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (rd_en == '0)); // R2

    AST_WAY0_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> rd_en[0]); // R3

    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> req_valid); // R5

    AST_HIT_WAY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> rd_en[hit_way]); // R8

    AST_VICTIM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> rd_en[victim_way]); // R8

    AST_MISS_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_way == '0)); // R10

endmodule

bind vw_cache_lookup vw_cache_lookup_chk #(
    .NUM_WAYS (NUM_WAYS),
    .WAY_W    (WAY_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .hit        (hit),
    .hit_way    (hit_way),
    .victim_way (victim_way),
    .rd_en      (rd_en)
);

// File: tb/tb_vw_cache_lookup.sv
`timescale 1ns/1ps
// Bench: vector table walk, then directed reset and corner checks.
module tb_vw_cache_lookup;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [11:0] req_addr;
    logic        fill_valid;
    logic [11:0] fill_addr;
    logic        hit;
    logic [1:0]  hit_way;
    logic [1:0]  victim_way;
    logic [3:0]  rd_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    vw_cache_lookup dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way),
        .rd_en      (rd_en)
    );

    typedef struct packed {
        logic       fill;
        logic [6:0] tag;
        logic [2:0] set;
        logic       hit;
        logic [1:0] way;
        logic [1:0] victim;
        logic [3:0] rden;
    } vec_t;

    // Expected values are the pre-fill view; a fill lands on the next edge.
    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 7'h11, 3'd0, 1'b0, 2'd0, 2'd0, 4'hF}, // R6 first fill set0
        '{1'b0, 7'h11, 3'd0, 1'b1, 2'd0, 2'd1, 4'hF}, // R4
        '{1'b1, 7'h22, 3'd0, 1'b0, 2'd0, 2'd1, 4'hF},
        '{1'b1, 7'h33, 3'd0, 1'b0, 2'd0, 2'd2, 4'hF},
        '{1'b1, 7'h44, 3'd0, 1'b0, 2'd0, 2'd3, 4'hF},
        '{1'b0, 7'h22, 3'd0, 1'b1, 2'd1, 2'd0, 4'hF}, // R6 wrap to 0
        '{1'b0, 7'h44, 3'd0, 1'b1, 2'd3, 2'd0, 4'hF},
        '{1'b1, 7'h55, 3'd0, 1'b0, 2'd0, 2'd0, 4'hF},
        '{1'b0, 7'h11, 3'd0, 1'b0, 2'd0, 2'd1, 4'hF}, // R7 evicted
        '{1'b0, 7'h55, 3'd0, 1'b1, 2'd0, 2'd1, 4'hF},
        '{1'b1, 7'h22, 3'd2, 1'b0, 2'd0, 2'd0, 4'h3}, // R9 same tag other set
        '{1'b1, 7'h33, 3'd2, 1'b0, 2'd0, 2'd1, 4'h3},
        '{1'b1, 7'h44, 3'd2, 1'b0, 2'd0, 2'd0, 4'h3}, // R6 2-way wrap
        '{1'b0, 7'h22, 3'd2, 1'b0, 2'd0, 2'd1, 4'h3}, // R7
        '{1'b0, 7'h33, 3'd2, 1'b1, 2'd1, 2'd1, 4'h3},
        '{1'b1, 7'h66, 3'd5, 1'b0, 2'd0, 2'd0, 4'h1},
        '{1'b0, 7'h66, 3'd5, 1'b1, 2'd0, 2'd0, 4'h1},
        '{1'b1, 7'h77, 3'd5, 1'b0, 2'd0, 2'd0, 4'h1}, // R6 1-way stays 0
        '{1'b0, 7'h66, 3'd5, 1'b0, 2'd0, 2'd0, 4'h1}, // R7
        '{1'b0, 7'h77, 3'd5, 1'b1, 2'd0, 2'd0, 4'h1},
        '{1'b0, 7'h22, 3'd0, 1'b1, 2'd1, 2'd1, 4'hF}, // R9 set0 untouched
        '{1'b0, 7'h00, 3'd7, 1'b0, 2'd0, 2'd0, 4'h1},
        '{1'b0, 7'h00, 3'd1, 1'b0, 2'd0, 2'd0, 4'hF},
        '{1'b0, 7'h00, 3'd3, 1'b0, 2'd0, 2'd0, 4'h3}
    };

    function automatic logic [11:0] mk_addr(input logic [6:0] tag, input logic [2:0] set);
        return {tag, set, 2'b01};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Drive at the falling edge, check 1 ns later, before the rising edge.
    task automatic apply(input logic rv, input logic [11:0] ra,
                         input logic fv, input logic [11:0] fa);
        @(negedge clk);
        req_valid  = rv;
        req_addr   = ra;
        fill_valid = fv;
        fill_addr  = fa;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        fill_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_addr = '0;
        fill_valid = 1'b0;
        fill_addr = '0;
        do_reset();

        // R1 reset state: idle outputs, then every set misses with victim 0
        apply(1'b0, '0, 1'b0, '0);
        check("R1 hit idle", hit, 0);
        check("R2 rd_en idle", rd_en, 0);
        for (int s = 0; s < 8; s++) begin
            apply(1'b1, mk_addr(7'h00, 3'(s)), 1'b0, '0);
            check("R1 hit after reset", hit, 0);
            check("R1 victim after reset", victim_way, 0);
            check("R3 way0 enabled", rd_en[0], 1);
            check("R2 rd_en by set", rd_en, (s < 2) ? 15 : (s < 4) ? 3 : 1);
        end

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(1'b1, mk_addr(VEC[i].tag, VEC[i].set), VEC[i].fill,
                  mk_addr(VEC[i].tag, VEC[i].set));
            check("R4 R5 hit", hit, VEC[i].hit);
            check("R10 R4 hit_way", hit_way, VEC[i].way);
            check("R6 victim", victim_way, VEC[i].victim);
            check("R2 rd_en", rd_en, VEC[i].rden);
        end

        // R5: stored line, no request -> no hit, no read
        apply(1'b0, mk_addr(7'h55, 3'd0), 1'b0, '0);
        check("R5 hit without request", hit, 0);
        check("R2 rd_en without request", rd_en, 0);

        // R6: fill with no request still advances set0 (was 1 -> 2)
        apply(1'b0, '0, 1'b1, mk_addr(7'h70, 3'd0));
        apply(1'b1, mk_addr(7'h70, 3'd0), 1'b0, '0);
        check("R4 fill without request hits", hit, 1);
        check("R4 fill way", hit_way, 1);
        check("R6 victim advanced", victim_way, 2);

        // R1: reset again clears contents and pointers
        do_reset();
        apply(1'b1, mk_addr(7'h70, 3'd0), 1'b0, '0);
        check("R1 contents cleared", hit, 0);
        check("R1 pointer cleared", victim_way, 0);

        finish_run();
    end

endmodule